// File: doc/BRIEF.md
# Linear CCD Clock Phase Sequencer

This block produces the pin-level clocks for a linear CCD image sensor: two shift phases, a read gate, a clamp pulse and a transfer gate. The sequences are built from logical "active" patterns. Each pattern passes through a fixed polarity mask (bitwise XOR) before it reaches the pins. Every state is held for a number of system-clock cycles set by a parameter. The defaults assume a 16 MHz clock.

Three requests are accepted while the block is idle:
- A line transfer moves charge from the photosites into the shift register.
- A single pixel shift moves one pixel to the sensor output. A one-cycle strobe marks the moment the pixel can be sampled.
- A flush clocks a long run of pixels with a stretched second phase and no strobe. It empties the register or lengthens exposure.

A request that arrives while a sequence runs has no effect. The downstream sampler uses `busy` to pace itself.

Top module: `ccd_phase_seq`

## Requirements
- R1: Throughout reset and on the first cycle after it, the pins read phi1=1, phi2=0, rd_gate=0, clamp=1, xfer_gate=1, and busy=0, pixel_valid=0.
- R2: At the pins, xfer_gate and clamp are active-low and phi1, phi2 and rd_gate are active-high (polarity mask applied by XOR).
- R3: While idle (busy=0), only phi1 is active.
- R4: start_transfer sampled high while idle starts the line transfer on the next cycle: phi1 alone for T_SETTLE cycles, then phi1 with xfer_gate for T_XFER cycles, then phi1 alone for T_POST cycles, then idle.
- R5: shift_req sampled high while idle runs one pixel in this order: phi1 alone (T_PH), phi1+rd_gate, phi1 alone (T_PH), phi1+clamp, phi1 alone (T_PH), then phi2 alone (T_P2), then idle.
- R6: rd_gate is active for T_RG cycles and clamp for T_CL cycles per pixel; the defaults make clamp one cycle longer.
- R7: pixel_valid is high for exactly one cycle, the first cycle of phi2 in a requested pixel shift.
- R8: flush_start sampled high while idle runs BULK_PIXELS pixel patterns back to back, with phi2 held T_GAP cycles each, and never raises pixel_valid.
- R9: Requests arriving while busy=1 are ignored, and busy stays high until the running sequence ends.
- R10: When several requests are high on an idle cycle, start_transfer wins over flush_start, which wins over shift_req.
- R11: phi1 and phi2 are never active together; xfer_gate, rd_gate and clamp are active only while phi1 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_transfer | input | 1 | Request a line (charge) transfer |
| flush_start | input | 1 | Request a bulk flush of BULK_PIXELS pixels |
| shift_req | input | 1 | Request one pixel shift |
| busy | output | 1 | A sequence is running |
| pixel_valid | output | 1 | One-cycle strobe: new pixel present at sensor output |
| phi1 | output | 1 | Shift phase 1 pin (active-high) |
| phi2 | output | 1 | Shift phase 2 pin (active-high) |
| rd_gate | output | 1 | Read/reset gate pin (active-high) |
| clamp | output | 1 | Clamp pin (active-low) |
| xfer_gate | output | 1 | Transfer gate pin (active-low) |

## Verification
Several patterns are applied:
- A single isolated shift request checks the six-step pixel order and the placement of the strobe.
- Holding shift_req high shows that back-to-back pixels are each separated by one idle cycle.
- A transfer with a shift request injected mid-sequence, and a flush with a transfer request injected, separate "ignored while busy" from a late restart.
- Simultaneous requests expose the priority order.
- The flush run tells a stretched, strobe-free phase 2 apart from a normal pixel.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_XF_PRE,
    ST_XF_ON,
    ST_XF_POST,
    ST_PX_A,
    ST_PX_RG,
    ST_PX_B,
    ST_PX_CL,
    ST_PX_C,
    ST_PX_P2
  } seq_state_e;

  typedef struct packed {
    logic tg;
    logic cl;
    logic rg;
    logic p2;
    logic p1;
  } ccd_lines_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Logical (active = 1) line pattern for each state.
  function automatic ccd_lines_t active_lines(seq_state_e s);
    ccd_lines_t l;
    l = '0;
    case (s)
      ST_XF_ON: begin l.p1 = 1'b1; l.tg = 1'b1; end
      ST_PX_RG: begin l.p1 = 1'b1; l.rg = 1'b1; end
      ST_PX_CL: begin l.p1 = 1'b1; l.cl = 1'b1; end
      ST_PX_P2: l.p2 = 1'b1;
      default:  l.p1 = 1'b1;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/ccd_hold_timer.sv
module ccd_hold_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
  import ccd_seq_pkg::*;
#(
  parameter int T_SETTLE    = 16,
  parameter int T_XFER      = 160,
  parameter int T_POST      = 24,
  parameter int T_PH        = 2,
  parameter int T_RG        = 3,
  parameter int T_CL        = 4,
  parameter int T_P2        = 8,
  parameter int T_GAP       = 4096,
  parameter int BULK_PIXELS = 1500,
  parameter int CW          = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_transfer,
  input  logic          flush_start,
  input  logic          shift_req,
  input  logic          tmr_done,
  output seq_state_e    state_q,
  output seq_state_e    state_d,
  output logic          bulk_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);

  localparam int PCW = (BULK_PIXELS > 1) ? $clog2(BULK_PIXELS) : 1;
  localparam logic [CW-1:0] D_SETTLE = CW'(T_SETTLE - 1);
  localparam logic [CW-1:0] D_XFER   = CW'(T_XFER - 1);
  localparam logic [CW-1:0] D_POST   = CW'(T_POST - 1);
  localparam logic [CW-1:0] D_PH     = CW'(T_PH - 1);
  localparam logic [CW-1:0] D_RG     = CW'(T_RG - 1);
  localparam logic [CW-1:0] D_CL     = CW'(T_CL - 1);
  localparam logic [CW-1:0] D_P2     = CW'(T_P2 - 1);
  localparam logic [CW-1:0] D_GAP    = CW'(T_GAP - 1);
  localparam logic [PCW-1:0] PIX_LAST = PCW'(BULK_PIXELS - 1);

  logic           bulk_q;
  logic [PCW-1:0] pix_q;
  logic [PCW-1:0] pix_d;

  always_comb begin
    state_d = state_q;
    bulk_d  = bulk_q;
    pix_d   = pix_q;
    case (state_q)
      ST_IDLE: begin
        if (start_transfer) begin
          state_d = ST_XF_PRE;
          bulk_d  = 1'b0;
        end else if (flush_start) begin
          state_d = ST_PX_A;
          bulk_d  = 1'b1;
          pix_d   = PIX_LAST;
        end else if (shift_req) begin
          state_d = ST_PX_A;
          bulk_d  = 1'b0;
        end
      end
      ST_XF_PRE:  if (tmr_done) state_d = ST_XF_ON;
      ST_XF_ON:   if (tmr_done) state_d = ST_XF_POST;
      ST_XF_POST: if (tmr_done) state_d = ST_IDLE;
      ST_PX_A:    if (tmr_done) state_d = ST_PX_RG;
      ST_PX_RG:   if (tmr_done) state_d = ST_PX_B;
      ST_PX_B:    if (tmr_done) state_d = ST_PX_CL;
      ST_PX_CL:   if (tmr_done) state_d = ST_PX_C;
      ST_PX_C:    if (tmr_done) state_d = ST_PX_P2;
      ST_PX_P2: begin
        if (tmr_done) begin
          if (bulk_q && (pix_q != '0)) begin
            state_d = ST_PX_A;
            pix_d   = pix_q - PCW'(1);
          end else begin
            state_d = ST_IDLE;
            bulk_d  = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    case (state_d)
      ST_XF_PRE:  tmr_val = D_SETTLE;
      ST_XF_ON:   tmr_val = D_XFER;
      ST_XF_POST: tmr_val = D_POST;
      ST_PX_A, ST_PX_B, ST_PX_C: tmr_val = D_PH;
      ST_PX_RG:   tmr_val = D_RG;
      ST_PX_CL:   tmr_val = D_CL;
      ST_PX_P2:   tmr_val = bulk_d ? D_GAP : D_P2;
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bulk_q  <= 1'b0;
      pix_q   <= '0;
    end else begin
      state_q <= state_d;
      bulk_q  <= bulk_d;
      pix_q   <= pix_d;
    end
  end

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tmr_done) |=> (state_q == $past(state_q))) // R5
    else $error("state left before its hold time elapsed");

  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XF_ON && !tmr_done) |=> (state_q == ST_XF_ON)) // R9
    else $error("transfer interrupted");

endmodule

// File: rtl/ccd_pin_driver.sv
module ccd_pin_driver
  import ccd_seq_pkg::*;
#(
  parameter logic [4:0] POL_MASK = 5'b11000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_q,
  input  seq_state_e state_d,
  input  logic       bulk_d,
  output ccd_lines_t pins,
  output logic       busy,
  output logic       pixel_valid
);

  localparam ccd_lines_t MASK     = ccd_lines_t'(POL_MASK);
  localparam ccd_lines_t IDLE_PIN = active_lines(ST_IDLE) ^ MASK;

  ccd_lines_t pins_d;
  logic       busy_d;
  logic       valid_d;

  always_comb begin
    pins_d  = active_lines(state_d) ^ MASK;
    busy_d  = (state_d != ST_IDLE);
    valid_d = (state_d == ST_PX_P2) && (state_q != ST_PX_P2) && !bulk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins        <= IDLE_PIN;
      busy        <= 1'b0;
      pixel_valid <= 1'b0;
    end else begin
      pins        <= pins_d;
      busy        <= busy_d;
      pixel_valid <= valid_d;
    end
  end

  ccd_lines_t act;
  assign act = pins ^ MASK;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(act.p1 && act.p2)) // R11
    else $error("both shift phases active");

  AST_GATE_NEEDS_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (act.tg || act.rg || act.cl) |-> act.p1) // R11
    else $error("gate pulse without phase 1");

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |=> !pixel_valid) // R7
    else $error("pixel_valid longer than one cycle");

  AST_VALID_ON_P2: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |-> (act.p2 && busy)) // R7
    else $error("pixel_valid without phase 2");

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (act.p1 && !act.p2 && !act.rg && !act.cl && !act.tg)) // R3
    else $error("idle pattern wrong");

endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccd_seq_pkg::*;
#(
  parameter int T_SETTLE    = 16,
  parameter int T_XFER      = 160,
  parameter int T_POST      = 24,
  parameter int T_PH        = 2,
  parameter int T_RG        = 3,
  parameter int T_CL        = 4,
  parameter int T_P2        = 8,
  parameter int T_GAP       = 4096,
  parameter int BULK_PIXELS = 1500,
  parameter logic [4:0] POL_MASK = 5'b11000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_transfer,
  input  logic flush_start,
  input  logic shift_req,
  output logic busy,
  output logic pixel_valid,
  output logic phi1,
  output logic phi2,
  output logic rd_gate,
  output logic clamp,
  output logic xfer_gate
);

  localparam int MAXD = imax(imax(imax(T_SETTLE, T_XFER), imax(T_POST, T_PH)),
                             imax(imax(T_RG, T_CL), imax(imax(T_P2, T_GAP), 2)));
  localparam int CW   = $clog2(MAXD);

  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  seq_state_e    state_q, state_d;
  logic          bulk_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  ccd_lines_t    pins;

  ccd_hold_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s2),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  ccd_seq_fsm #(
    .T_SETTLE(T_SETTLE), .T_XFER(T_XFER), .T_POST(T_POST), .T_PH(T_PH),
    .T_RG(T_RG), .T_CL(T_CL), .T_P2(T_P2), .T_GAP(T_GAP),
    .BULK_PIXELS(BULK_PIXELS), .CW(CW)
  ) u_fsm (
    .clk            (clk),
    .rst_n          (rst_s2),
    .start_transfer (start_transfer),
    .flush_start    (flush_start),
    .shift_req      (shift_req),
    .tmr_done       (tmr_done),
    .state_q        (state_q),
    .state_d        (state_d),
    .bulk_d         (bulk_d),
    .tmr_load       (tmr_load),
    .tmr_val        (tmr_val)
  );

  ccd_pin_driver #(.POL_MASK(POL_MASK)) u_drv (
    .clk         (clk),
    .rst_n       (rst_s2),
    .state_q     (state_q),
    .state_d     (state_d),
    .bulk_d      (bulk_d),
    .pins        (pins),
    .busy        (busy),
    .pixel_valid (pixel_valid)
  );

  assign phi1      = pins.p1;
  assign phi2      = pins.p2;
  assign rd_gate   = pins.rg;
  assign clamp     = pins.cl;
  assign xfer_gate = pins.tg;

endmodule

// File: tb/tb_ccd_phase_seq.sv
module tb_ccd_phase_seq;

  localparam int T_SETTLE = 4, T_XFER = 10, T_POST = 5, T_PH = 2;
  localparam int T_RG = 3, T_CL = 4, T_P2 = 6, T_GAP = 9, NPIX = 3;

  logic clk, rst_n, start_transfer, flush_start, shift_req;
  logic busy, pixel_valid, phi1, phi2, rd_gate, clamp, xfer_gate;

  ccd_phase_seq #(
    .T_SETTLE(T_SETTLE), .T_XFER(T_XFER), .T_POST(T_POST), .T_PH(T_PH),
    .T_RG(T_RG), .T_CL(T_CL), .T_P2(T_P2), .T_GAP(T_GAP), .BULK_PIXELS(NPIX)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_transfer(start_transfer),
    .flush_start(flush_start), .shift_req(shift_req), .busy(busy),
    .pixel_valid(pixel_valid), .phi1(phi1), .phi2(phi2), .rd_gate(rd_gate),
    .clamp(clamp), .xfer_gate(xfer_gate)
  );

  // logical expectation: busy, valid, tg, cl, rg, p2, p1 (active = 1)
  typedef struct packed {
    logic b; logic v; logic tg; logic cl; logic rg; logic p2; logic p1;
  } exp_t;

  localparam exp_t IDLE_E = 7'b0000001;

  exp_t  q[$];
  exp_t  cur;
  logic  mr1, mr2;
  int    total, bad;
  string tag;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic push(int n, exp_t e);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic push_pixel(int p2len, logic strobe);
    push(T_PH, 7'b1000001);
    push(T_RG, 7'b1000101);
    push(T_PH, 7'b1000001);
    push(T_CL, 7'b1001001);
    push(T_PH, 7'b1000001);
    q.push_back({1'b1, strobe, 5'b00010});
    push(p2len - 1, 7'b1000010);
  endtask

  // reference model, includes the two-stage reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 1'b0; mr2 = 1'b0; q.delete(); cur = IDLE_E;
    end else begin
      if (mr2) begin
        if (q.size() > 0) cur = q.pop_front();
        else if (!cur.b && (start_transfer || flush_start || shift_req)) begin
          if (start_transfer) begin
            push(T_SETTLE, 7'b1000001);
            push(T_XFER,   7'b1010001);
            push(T_POST,   7'b1000001);
          end else if (flush_start) begin
            for (int k = 0; k < NPIX; k++) push_pixel(T_GAP, 1'b0);
          end else begin
            push_pixel(T_P2, 1'b1);
          end
          cur = q.pop_front();
        end else cur = IDLE_E;
      end
      mr2 = mr1; mr1 = 1'b1;
    end
  end

  task automatic chk(string t, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (pins: tg, cl active-low per R2)
  always @(negedge clk) begin
    chk({tag, " phi1"},  phi1,        cur.p1);
    chk({tag, " phi2"},  phi2,        cur.p2);
    chk({tag, " rd R6"}, rd_gate,     cur.rg);
    chk({tag, " cl R6"}, clamp,       ~cur.cl);
    chk({tag, " tg R4"}, xfer_gate,   ~cur.tg);
    chk({tag, " valid R7"}, pixel_valid, cur.v);
    chk({tag, " busy R9"},  busy,     cur.b);
  end

  task automatic req(int which);
    @(negedge clk);
    start_transfer = (which == 0);
    flush_start    = (which == 1);
    shift_req      = (which == 2);
    @(negedge clk);
    start_transfer = 1'b0; flush_start = 1'b0; shift_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0; tag = "R1";
    start_transfer = 1'b0; flush_start = 1'b0; shift_req = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    idle(3);
    chk("R1 reset phi1", phi1, 1'b1);
    chk("R1 reset clamp", clamp, 1'b1);
    chk("R1 reset xfer_gate", xfer_gate, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 after release pixel_valid", pixel_valid, 1'b0);
    idle(4);
    tag = "R3";
    chk("R3 idle phi2", phi2, 1'b0);
    chk("R3 idle rd_gate", rd_gate, 1'b0);

    tag = "R5";
    req(2);
    idle(30);

    tag = "R5 held";
    @(negedge clk); shift_req = 1'b1;
    idle(60);
    shift_req = 1'b0;
    idle(30);

    tag = "R4";
    @(negedge clk); start_transfer = 1'b1;
    @(negedge clk); start_transfer = 1'b0;
    idle(5);
    chk("R2 xfer_gate low when active", xfer_gate, 1'b0);
    chk("R2 phi1 high with transfer", phi1, 1'b1);
    tag = "R9";
    shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
    idle(25);

    tag = "R8";
    req(1);
    idle(10);
    tag = "R9 flush";
    start_transfer = 1'b1;
    @(negedge clk); start_transfer = 1'b0;
    idle(80);

    tag = "R10";
    @(negedge clk); start_transfer = 1'b1; flush_start = 1'b1; shift_req = 1'b1;
    @(negedge clk); start_transfer = 1'b0; flush_start = 1'b0; shift_req = 1'b0;
    idle(30);
    @(negedge clk); flush_start = 1'b1; shift_req = 1'b1;
    @(negedge clk); flush_start = 1'b0; shift_req = 1'b0;
    idle(80);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule